// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block is a synchronous static memory with a two-register read pipeline and a four-beat burst engine, meant to stand in for an external burst cache memory inside a larger design. Its data path is 36 bits wide, arranged as four 9-bit byte lanes (eight data bits plus one parity bit each), and it holds a small array whose depth is a parameter. The data bus is split into an input port, an output port and an output-drive flag.

A burst is opened by one of two active-low strobes. The processor strobe always opens a read and takes priority. The controller strobe opens a read or a write, decided by the write controls on the same edge. After the opening edge, a step input either moves the 2-bit beat counter or holds it, which inserts a wait state. The beat order is linear or interleaved, chosen by an input. Writes can cover all lanes at once or selected lanes only. Three chip selects allow depth expansion. An asynchronous output enable gates the drivers. A sleep input freezes the block and keeps the array contents. It is followed by a recovery window in which strobes are refused and recorded in a sticky error flag.

Top module: `psb_sram`

## Requirements
- R1: After reset, `dout_en_o` and `proto_err_o` are low.
- R2: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. An edge that samples an effective strobe with any other select combination performs no access and ends the open burst. With `sel1_n`=1 the processor strobe has no effect.
- R3: An edge that samples `cpu_strobe_n`=0 with the block selected opens a read burst at `addr_i`. On that edge the write controls, `ctl_strobe_n` and `step_n` are ignored.
- R4: When the processor strobe is not in effect, `ctl_strobe_n`=0 with the block selected opens a burst at `addr_i`. The write controls are sampled on that same edge, so the opening beat may be a write.
- R5: Each edge that samples no strobe while a burst is open accesses the next beat when `step_n`=0 and the same beat when `step_n`=1. The access is a read or a write according to the write controls on that edge.
- R6: The two low bits of `addr_i` are the start beat s, and the upper bits stay fixed for the whole burst. After k steps the low bits are (s+k) mod 4 when `interleave_i`=0 and s XOR k when `interleave_i`=1. After four steps the beat is back at s.
- R7: A read sampled on edge N drives its word on `dout_o`, with `dout_en_o` high if `out_en_n`=0, after edge N+1 and not before.
- R8: With `all_wr_n`=0, all lanes are written. Otherwise lane i (bits 9i+8..9i) is written when `byte_wr_n`=0 and `lane_wr_n[i]`=0. If no lane qualifies, the access is a read.
- R9: After an edge that samples a write, `dout_en_o` is low even with `out_en_n`=0. `out_en_n`=1 drops `dout_en_o` at once, without waiting for a clock edge.
- R10: `sleep_i`=1 drops `dout_en_o` at once and blocks every access while it is sampled high. The array contents are kept. The block is asleep only after two consecutive edges sample `sleep_i` high; a one-edge pulse leaves no recovery window.
- R11: After sleep, the first two edges that sample `sleep_i` low perform no access. A strobe sampled on either of those edges sets `proto_err_o`, which stays high until reset.
- R12: A continue edge while no burst is open performs no access, and `dout_en_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address; low BEAT_W bits are the start beat |
| cpu_strobe_n | input | 1 | Processor burst strobe, active low, read start |
| ctl_strobe_n | input | 1 | Controller burst strobe, active low |
| step_n | input | 1 | Burst advance, active low; high holds the beat |
| sel1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Lane write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| interleave_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| din_i | input | LANES*LANE_W | Write data |
| dout_o | output | LANES*LANE_W | Read data |
| dout_en_o | output | 1 | High when `dout_o` should be driven |
| proto_err_o | output | 1 | Sticky flag: strobe during wake-up recovery |

## Verification
Two functions can meet on one edge. First, both strobes can be asserted together; the bench does this with a global write pending on the controller strobe, and then judges both the returned data and a later re-read of the same word to confirm that the processor-strobe read won and nothing was written. Second, a write can be sampled on the edge that would otherwise move an earlier read into the output register; the bench issues a read and then a write on the next edge, expects the output drive to be off after that edge, and then reads the written word back.

// File: rtl/psb_pkg.sv
`timescale 1ns/1ps
package psb_pkg;

   typedef enum logic [1:0] {
      PWR_AWAKE   = 2'd0,
      PWR_ASLEEP  = 2'd1,
      PWR_RECOVER = 2'd2
   } pwr_state_t;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_DESEL = 2'd1,
      CMD_START = 2'd2,
      CMD_CONT  = 2'd3
   } cmd_t;

endpackage

// File: rtl/psb_power.sv
`timescale 1ns/1ps
module psb_power import psb_pkg::*; #(
   parameter int SLEEP_CYC = 2,
   parameter int WAKE_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic strobe_any_i,
   output logic gate_o,
   output logic rec_o,
   output logic err_o
);
   localparam int MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   pwr_state_t    state;
   logic [CW-1:0] cnt;

   always_comb begin
      gate_o = !sleep_i && (state == PWR_AWAKE);
      rec_o  = !sleep_i && (state != PWR_AWAKE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PWR_AWAKE;
         cnt   <= '0;
         err_o <= 1'b0;
      end else begin
         if (rec_o && strobe_any_i) err_o <= 1'b1;
         case (state)
            PWR_AWAKE: begin
               if (sleep_i) begin
                  if (cnt == CW'(SLEEP_CYC - 1)) begin
                     state <= PWR_ASLEEP;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else begin
                  cnt <= '0;
               end
            end
            PWR_ASLEEP: begin
               if (!sleep_i) begin
                  state <= PWR_RECOVER;
                  cnt   <= CW'(WAKE_CYC - 1);
               end
            end
            PWR_RECOVER: begin
               if (sleep_i) begin
                  state <= PWR_ASLEEP;
                  cnt   <= '0;
               end else if (cnt == CW'(1)) begin
                  state <= PWR_AWAKE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               state <= PWR_AWAKE;
               cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/psb_burst_ctl.sv
`timescale 1ns/1ps
module psb_burst_ctl import psb_pkg::*; #(
   parameter int ADDR_W = 6,
   parameter int BEAT_W = 2,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cpu_strobe_n,
   input  logic              ctl_strobe_n,
   input  logic              step_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic              all_wr_n,
   input  logic              byte_wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic              interleave_i,
   output logic              acc_o,
   output logic [LANES-1:0]  wr_mask_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - BEAT_W;

   logic              active;
   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;

   logic              selected;
   logic              cpu_req;
   logic              ctl_req;
   logic [LANES-1:0]  lanes_req;
   logic [BEAT_W-1:0] beat_nxt;
   logic [BEAT_W-1:0] seq_lo;
   cmd_t              cmd;

   always_comb begin
      selected  = !sel1_n && sel2 && !sel3_n;
      cpu_req   = !cpu_strobe_n && !sel1_n;
      ctl_req   = !ctl_strobe_n && !cpu_req;
      lanes_req = all_wr_n ? ({LANES{!byte_wr_n}} & ~lane_wr_n) : {LANES{1'b1}};
      beat_nxt  = step_n ? beat_q : beat_q + 1'b1;
      seq_lo    = interleave_i ? (start_q ^ beat_nxt) : (start_q + beat_nxt);

      if (!gate_i)                   cmd = CMD_NOP;
      else if (cpu_req || ctl_req)   cmd = selected ? CMD_START : CMD_DESEL;
      else if (active)               cmd = CMD_CONT;
      else                           cmd = CMD_NOP;

      acc_o  = (cmd == CMD_START) || (cmd == CMD_CONT);
      addr_o = (cmd == CMD_START) ? addr_i : {hi_q, seq_lo};
      if ((cmd == CMD_CONT) || ((cmd == CMD_START) && !cpu_req))
         wr_mask_o = lanes_req;
      else
         wr_mask_o = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         hi_q    <= '0;
         start_q <= '0;
         beat_q  <= '0;
      end else begin
         case (cmd)
            CMD_START: begin
               active  <= 1'b1;
               hi_q    <= addr_i[ADDR_W-1:BEAT_W];
               start_q <= addr_i[BEAT_W-1:0];
               beat_q  <= '0;
            end
            CMD_DESEL: active <= 1'b0;
            CMD_CONT:  beat_q <= beat_nxt;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/psb_array.sv
`timescale 1ns/1ps
module psb_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_i,
   input  logic [LANES-1:0]        wr_mask_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] din_i,
   output logic [LANES*LANE_W-1:0] q_o,
   output logic                    q_vld_o
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              rd;
   logic              wr_any;
   logic [DATA_W-1:0] stage1;
   logic              v1;

   assign rd     = acc_i && (wr_mask_i == '0);
   assign wr_any = acc_i && (wr_mask_i != '0);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (acc_i && wr_mask_i[g]) bank[addr_i] <= din_i[g*LANE_W +: LANE_W];
         if (rd) rd_q <= bank[addr_i];
      end
      assign stage1[g*LANE_W +: LANE_W] = rd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1      <= 1'b0;
         q_vld_o <= 1'b0;
         q_o     <= '0;
      end else begin
         v1      <= rd;
         q_vld_o <= v1 && !wr_any;
         if (v1) q_o <= stage1;
      end
   end
endmodule

// File: rtl/psb_sram.sv
`timescale 1ns/1ps
module psb_sram #(
   parameter int ADDR_W    = 6,
   parameter int BEAT_W    = 2,
   parameter int LANES     = 4,
   parameter int LANE_W    = 9,
   parameter int SLEEP_CYC = 2,
   parameter int WAKE_CYC  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    cpu_strobe_n,
   input  logic                    ctl_strobe_n,
   input  logic                    step_n,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    all_wr_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    interleave_i,
   input  logic                    out_en_n,
   input  logic                    sleep_i,
   input  logic [LANES*LANE_W-1:0] din_i,
   output logic [LANES*LANE_W-1:0] dout_o,
   output logic                    dout_en_o,
   output logic                    proto_err_o
);
   localparam int DATA_W = LANES * LANE_W;

   if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_beat
      $error("psb_sram: BEAT_W must be at least 1 and below ADDR_W");
   end
   if (WAKE_CYC < 2) begin : g_bad_wake
      $error("psb_sram: WAKE_CYC must be at least 2");
   end
   if (SLEEP_CYC < 1) begin : g_bad_sleep
      $error("psb_sram: SLEEP_CYC must be at least 1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("psb_sram: lane count and width must be positive");
   end

   logic              gate_w;
   logic              rec_w;
   logic              acc_w;
   logic [LANES-1:0]  wr_mask_w;
   logic [ADDR_W-1:0] addr_w;
   logic              q_vld_w;
   logic [DATA_W-1:0] q_w;

   psb_power #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_power (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_i      (sleep_i),
      .strobe_any_i (!cpu_strobe_n || !ctl_strobe_n),
      .gate_o       (gate_w),
      .rec_o        (rec_w),
      .err_o        (proto_err_o)
   );

   psb_burst_ctl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LANES(LANES)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .gate_i       (gate_w),
      .addr_i       (addr_i),
      .cpu_strobe_n (cpu_strobe_n),
      .ctl_strobe_n (ctl_strobe_n),
      .step_n       (step_n),
      .sel1_n       (sel1_n),
      .sel2         (sel2),
      .sel3_n       (sel3_n),
      .all_wr_n     (all_wr_n),
      .byte_wr_n    (byte_wr_n),
      .lane_wr_n    (lane_wr_n),
      .interleave_i (interleave_i),
      .acc_o        (acc_w),
      .wr_mask_o    (wr_mask_w),
      .addr_o       (addr_w)
   );

   psb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_i     (acc_w),
      .wr_mask_i (wr_mask_w),
      .addr_i    (addr_w),
      .din_i     (din_i),
      .q_o       (q_w),
      .q_vld_o   (q_vld_w)
   );

   assign dout_o    = q_w;
   assign dout_en_o = q_vld_w && !out_en_n && !sleep_i;
endmodule

// File: rtl/psb_sram_chk.sv
`timescale 1ns/1ps
module psb_sram_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_strobe_n,
   input logic              ctl_strobe_n,
   input logic              step_n,
   input logic              sel1_n,
   input logic              sel2,
   input logic              sel3_n,
   input logic              interleave_i,
   input logic              sleep_i,
   input logic              dout_en_o,
   input logic              proto_err_o,
   input logic              gate,
   input logic              rec,
   input logic              acc,
   input logic [LANES-1:0]  wr_mask,
   input logic [ADDR_W-1:0] addr
);
   logic up;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up <= 1'b0;
      else        up <= 1'b1;
   end

   AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && ((!cpu_strobe_n && !sel1_n) || !ctl_strobe_n) && !(!sel1_n && sel2 && !sel3_n)) |-> !acc); // R2

   AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !cpu_strobe_n && !sel1_n) |-> (wr_mask == '0)); // R3

   AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (up && acc && $past(acc) && ctl_strobe_n && (cpu_strobe_n || sel1_n) && step_n && $stable(interleave_i))
      |-> $stable(addr)); // R5

   AST_WRITE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (wr_mask != '0)) |=> !dout_en_o); // R9

   AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !acc); // R10

   AST_RECOVERY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rec |-> !acc); // R11

   AST_RECOVERY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rec && (!cpu_strobe_n || !ctl_strobe_n)) |=> proto_err_o); // R11

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o); // R11

   logic unused_ok;
   assign unused_ok = step_n;
endmodule

bind psb_sram psb_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_strobe_n (cpu_strobe_n),
   .ctl_strobe_n (ctl_strobe_n),
   .step_n       (step_n),
   .sel1_n       (sel1_n),
   .sel2         (sel2),
   .sel3_n       (sel3_n),
   .interleave_i (interleave_i),
   .sleep_i      (sleep_i),
   .dout_en_o    (dout_en_o),
   .proto_err_o  (proto_err_o),
   .gate         (gate_w),
   .rec          (rec_w),
   .acc          (acc_w),
   .wr_mask      (wr_mask_w),
   .addr         (addr_w)
);

// File: tb/psb_sram_test.sv
`timescale 1ns/1ps
module psb_sram_test;
   localparam int ADDR_W = 6;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int DW     = LANES * LANE_W;

   // {interleave, start[1:0], beat0, beat1, beat2, beat3}  (R6)
   localparam logic [10:0] VEC [8] = '{
      11'b0_00_00011011, 11'b0_01_01101100, 11'b0_10_10110001, 11'b0_11_11000110,
      11'b1_00_00011011, 11'b1_01_01001110, 11'b1_10_10110001, 11'b1_11_11100100
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1;
   logic              sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic              all_wr_n = 1'b1, byte_wr_n = 1'b1;
   logic [LANES-1:0]  lane_wr_n = '1;
   logic              interleave_i = 1'b0, out_en_n = 1'b0, sleep_i = 1'b0;
   logic [DW-1:0]     din_i = '0;
   logic [DW-1:0]     dout_o;
   logic              dout_en_o, proto_err_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [DW-1:0] shadow [64];

   always #2.5 clk = ~clk;

   psb_sram uut (.*);

   function automatic logic [DW-1:0] pat(int a);
      return 36'(a) * 36'h0_0103_0507 + 36'h9_0000_0001;
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rest();
      cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
      all_wr_n = 1; byte_wr_n = 1; lane_wr_n = '1;
      sel1_n = 0; sel2 = 1; sel3_n = 0;
   endtask

   task automatic desel();
      rest(); cpu_strobe_n = 0; sel2 = 0; tick(); rest();
   endtask

   task automatic read_check(string tag, int a);
      rest(); ctl_strobe_n = 0; addr_i = 6'(a); tick();
      rest(); tick();
      check({tag, " drive"}, 36'(dout_en_o), 36'd1);
      check(tag, dout_o, shadow[a]);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 drive after reset", 36'(dout_en_o), 36'd0);
      check("R1 error after reset", 36'(proto_err_o), 36'd0);
      rst_n = 1;
      tick();

      // fill the array with single controller-strobe writes (R4, R8)
      for (int a = 0; a < 64; a++) begin
         rest(); ctl_strobe_n = 0; all_wr_n = 0; addr_i = 6'(a);
         din_i = pat(a); shadow[a] = pat(a); tick();
      end
      desel(); tick();

      // burst order table (R3, R5, R6, R7)
      for (int i = 0; i < 8; i++) begin
         logic [10:0] v;
         logic [1:0]  e [4];
         v = VEC[i];
         for (int k = 0; k < 4; k++) e[k] = v[7-2*k -: 2];
         interleave_i = v[10];
         rest(); cpu_strobe_n = 0; ctl_strobe_n = 0; all_wr_n = 0; step_n = 0;
         din_i = '0; addr_i = {4'(i), v[9:8]};
         tick();
         rest(); step_n = 0;
         for (int k = 0; k < 4; k++) begin
            tick();
            check($sformatf("R6 vec%0d beat%0d", i, k), dout_o, shadow[{4'(i), e[k]}]);
         end
         desel();
         check($sformatf("R6 vec%0d wrap", i), dout_o, shadow[{4'(i), e[0]}]);
      end
      interleave_i = 0;
      tick();

      // R12: continue with no open burst
      rest(); step_n = 0; tick(); tick();
      check("R12 no burst stays off", 36'(dout_en_o), 36'd0);

      // R5: suspend then advance
      rest(); cpu_strobe_n = 0; addr_i = 6'd20; tick();
      rest(); tick();
      check("R5 first beat", dout_o, shadow[20]);
      step_n = 0; tick();
      check("R5 suspend repeats", dout_o, shadow[20]);
      step_n = 1; tick();
      check("R5 advance next", dout_o, shadow[21]);
      desel();

      // R8: lanes 0 and 2 written (lane_wr_n bit i = 0 enables lane i)
      rest(); ctl_strobe_n = 0; byte_wr_n = 0; lane_wr_n = 4'b1010;
      addr_i = 6'd30; din_i = '1; tick();
      shadow[30][8:0] = 9'h1FF; shadow[30][26:18] = 9'h1FF;
      desel();
      read_check("R8 lane write", 30);
      desel();

      // R8: lane enables without byte_wr_n is a read
      rest(); ctl_strobe_n = 0; byte_wr_n = 1; lane_wr_n = 4'b0000;
      addr_i = 6'd31; din_i = 36'h0DEAD0BEE; tick();
      rest(); tick();
      check("R8 unqualified is read drive", 36'(dout_en_o), 36'd1);
      check("R8 unqualified is read data", dout_o, shadow[31]);
      desel();

      // R8: global write overrides lane enables
      rest(); ctl_strobe_n = 0; all_wr_n = 0; byte_wr_n = 1; lane_wr_n = '1;
      addr_i = 6'd32; din_i = 36'h123456789; tick();
      shadow[32] = 36'h123456789;
      desel();
      read_check("R8 global write", 32);
      desel();

      // R3: both strobes on one edge, processor wins as a read
      rest(); cpu_strobe_n = 0; ctl_strobe_n = 0; all_wr_n = 0;
      addr_i = 6'd33; din_i = 36'h0BADBADBA; tick();
      rest(); tick();
      check("R3 strobe clash reads", dout_o, shadow[33]);
      tick();
      check("R3 strobe clash no write", dout_o, shadow[33]);
      desel();

      // R2: sel1_n high blocks the processor strobe, burst continues
      rest(); cpu_strobe_n = 0; addr_i = 6'd40; tick();
      rest(); cpu_strobe_n = 0; sel1_n = 1; step_n = 0; addr_i = 6'd0; tick();
      rest(); tick();
      check("R2 blocked strobe continues", dout_o, shadow[41]);

      // R2: wrong select on a strobe edge ends the burst and writes nothing
      rest(); ctl_strobe_n = 0; sel3_n = 1; all_wr_n = 0; addr_i = 6'd42;
      din_i = 36'h0FACEFACE; tick();
      rest(); step_n = 0; tick(); tick();
      check("R2 deselect ends burst", 36'(dout_en_o), 36'd0);
      read_check("R2 deselect no write", 42);
      desel();

      // R9: write right after read blanks output
      rest(); ctl_strobe_n = 0; addr_i = 6'd43; tick();
      rest(); ctl_strobe_n = 0; all_wr_n = 0; addr_i = 6'd44; din_i = 36'h55AA55AA5; tick();
      shadow[44] = 36'h55AA55AA5;
      check("R9 write blanks drive", 36'(dout_en_o), 36'd0);
      rest(); tick(); tick();
      check("R9 written word", dout_o, shadow[44]);

      // R9: asynchronous output enable
      check("R9 drive before oe", 36'(dout_en_o), 36'd1);
      out_en_n = 1; #1;
      check("R9 oe high drops drive", 36'(dout_en_o), 36'd0);
      out_en_n = 0; #1;
      check("R9 oe low restores drive", 36'(dout_en_o), 36'd1);
      desel(); tick();

      // R7: latency
      rest(); ctl_strobe_n = 0; addr_i = 6'd46; tick();
      check("R7 not after first edge", 36'(dout_en_o), 36'd0);
      rest(); tick();
      check("R7 after second edge drive", 36'(dout_en_o), 36'd1);
      check("R7 after second edge data", dout_o, shadow[46]);

      // R10: short pulse, async drop, no recovery window
      sleep_i = 1; #1;
      check("R10 sleep drops drive", 36'(dout_en_o), 36'd0);
      tick();
      sleep_i = 0;
      read_check("R10 short pulse no recovery", 47);
      check("R10 short pulse no error", 36'(proto_err_o), 36'd0);

      // R10, R11: full sleep, strobe during sleep and recovery
      rest(); sleep_i = 1; ctl_strobe_n = 0; all_wr_n = 0; addr_i = 6'd48;
      din_i = 36'h0AAAAAAAA; tick(); tick(); tick();
      check("R10 strobe while asleep no error", 36'(proto_err_o), 36'd0);
      sleep_i = 0; addr_i = 6'd49; tick();
      check("R11 recovery strobe flags", 36'(proto_err_o), 36'd1);
      rest(); tick();
      read_check("R10 contents kept", 48);
      read_check("R11 recovery write ignored", 49);
      check("R11 error sticky", 36'(proto_err_o), 36'd1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule